// File: doc/BRIEF.md
# Eight-Slot Status LED Blinker

This block drives a single status LED so that an operator can read the board's power-sequencing progress from the light alone. Time is cut into slots of roughly 1/5.8 s by a clock prescaler, and eight consecutive slots form a frame that repeats at about 0.7 Hz. Each power state lights a different number of leading slots in the frame. The power state is a 2-bit input driven by the sequencer, and a separate flag reports whether the FPGA has finished configuration.

Two states do not use the frame. The idle error state blinks the LED fast by toggling it at every slot boundary. The ready-and-configured state holds the LED on solidly. The inputs are sampled only at slot boundaries, so a status change mid-slot shows up at the next boundary and the frame position carries on without a restart.

The prescaler divisor is computed from the clock frequency by default. A test environment can override it so that a frame takes only a few dozen cycles.

Top module: `led_status_blinker`

## Requirements
- R1: While reset is asserted, and during slot 0 after reset is released, the LED is off. Reset forces the LED off at once, without waiting for a clock edge.
- R2: A slot boundary happens once every TICK_DIV clock cycles. The LED changes only at a slot boundary and holds its value for the whole slot.
- R3: With power state 2'b01 (first rail group coming up), the LED is lit in slots 0 to 4 of every frame and dark in slots 5 to 7.
- R4: With power state 2'b10 (second rail group coming up), the LED is lit in slots 0 to 3 and dark in slots 4 to 7.
- R5: With power state 2'b11 (all rails good) and the configured flag low, the LED is lit in slots 0 to 2 and dark in slots 3 to 7.
- R6: With power state 2'b11 and the configured flag high, the LED is on in every slot.
- R7: With power state 2'b00 (idle error), the LED inverts its previous value at every slot boundary. This gives a blink at half the slot rate.
- R8: The inputs are sampled only at a slot boundary. A status change in mid-slot leaves the current slot's LED value untouched and applies from the next boundary. The slot index keeps counting through the change and is not reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| pwr_state_i | input | 2 | Power state: 00 idle error, 01 first group, 10 second group, 11 all good |
| cfg_done_i | input | 1 | High once the FPGA has been configured |
| led_o | output | 1 | LED drive, high means lit |

## Verification
The slot-boundary update and a status change can fall in the same cycle, and a status change can also arrive halfway through a slot. The bench changes the inputs right after a boundary and again in mid-slot, always at a falling clock edge. At every falling edge it compares the LED against a slot model that it keeps itself. That model applies the new status only from the next boundary, and it continues the slot index through the change. The bench confirms the frame phase after the change and confirms that the remainder of the interrupted slot is unchanged.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  typedef enum logic [1:0] {
    PWR_IDLE  = 2'b00,
    PWR_GRP1  = 2'b01,
    PWR_GRP2  = 2'b10,
    PWR_READY = 2'b11
  } pwr_state_e;

  typedef enum logic [1:0] {
    SHOW_TOGGLE,
    SHOW_FRAME,
    SHOW_SOLID
  } show_mode_e;

endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned SLOTS    = 8,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned CNT_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);

  logic              tick;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_inc;
  logic [SLOT_W-1:0] slot_d;
  logic              slot_en;

  generate
    if (TICK_DIV <= 1) begin : g_no_div
      assign tick = 1'b1;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_last;

      always_comb begin
        cnt_last = (cnt_q == CNT_W'(TICK_DIV - 1));
        cnt_d    = cnt_last ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = cnt_last;

      // R2
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TICK_DIV - 1));
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  always_comb begin
    if (SLOTS == (1 << SLOT_W)) begin
      slot_inc = slot_q + 1'b1;
    end else begin
      slot_inc = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
    slot_en = tick;
    slot_d  = slot_en ? slot_inc : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  assign tick_o     = tick;
  assign slot_o     = slot_q;
  assign slot_nxt_o = slot_inc;

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot_q));
  // R8
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (slot_q != $past(slot_q)));

endmodule

// File: rtl/led_pattern.sv
module led_pattern
  import led_blink_pkg::*;
#(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned LIT_GRP1  = 5,
  parameter int unsigned LIT_GRP2  = 4,
  parameter int unsigned LIT_READY = 3,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned LIT_W    = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slot_nxt_i,
  input  logic [1:0]        pwr_state_i,
  input  logic              cfg_done_i,
  output logic              led_o
);

  pwr_state_e  pwr;
  show_mode_e  mode;
  logic [LIT_W-1:0] lit_cnt;
  logic        frame_on;
  logic        led_q;
  logic        led_d;
  logic        led_en;

  always_comb begin
    pwr     = pwr_state_e'(pwr_state_i);
    mode    = SHOW_FRAME;
    lit_cnt = '0;
    unique case (pwr)
      PWR_IDLE: begin
        mode = SHOW_TOGGLE;
      end
      PWR_GRP1: begin
        lit_cnt = LIT_W'(LIT_GRP1);
      end
      PWR_GRP2: begin
        lit_cnt = LIT_W'(LIT_GRP2);
      end
      PWR_READY: begin
        if (cfg_done_i) begin
          mode = SHOW_SOLID;
        end else begin
          lit_cnt = LIT_W'(LIT_READY);
        end
      end
      default: begin
        mode = SHOW_TOGGLE;
      end
    endcase
  end

  always_comb begin
    frame_on = ({1'b0, slot_nxt_i} < lit_cnt);
    led_en   = tick_i;
    unique case (mode)
      SHOW_TOGGLE: led_d = ~led_q;
      SHOW_SOLID:  led_d = 1'b1;
      SHOW_FRAME:  led_d = frame_on;
      default:     led_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= 1'b0;
    end else if (led_en) begin
      led_q <= led_d;
    end
  end

  assign led_o = led_q;

  // R2
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(led_q));
  // R7
  idle_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pwr_state_i == 2'b00) |=> (led_q != $past(led_q)));
  // R6
  solid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pwr_state_i == 2'b11 && cfg_done_i) |=> led_q);
  // R3 R4 R5
  frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pwr_state_i != 2'b00 && !(pwr_state_i == 2'b11 && cfg_done_i)
     && slot_nxt_i == '0) |=> led_q);
  // R3 R4 R5
  frame_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pwr_state_i != 2'b00 && !(pwr_state_i == 2'b11 && cfg_done_i)
     && slot_nxt_i == SLOT_W'(SLOTS - 1)) |=> !led_q);

endmodule

// File: rtl/led_status_blinker.sv
module led_status_blinker #(
  parameter int unsigned CLK_FREQ_HZ   = 25_000_000,
  parameter int unsigned SLOT_RATE_DHZ = 58,
  parameter int unsigned TICK_DIV      = (CLK_FREQ_HZ / SLOT_RATE_DHZ) * 10,
  parameter int unsigned SLOTS         = 8,
  parameter int unsigned LIT_GRP1      = 5,
  parameter int unsigned LIT_GRP2      = 4,
  parameter int unsigned LIT_READY     = 3,
  localparam int unsigned SLOT_W       = $clog2(SLOTS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state_i,
  input  logic       cfg_done_i,
  output logic       led_o
);

  logic              rst_core_n;
  logic              tick;
  logic [SLOT_W-1:0] slot_cur;
  logic [SLOT_W-1:0] slot_nxt;

  led_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_core_n)
  );

  led_slot_timer #(
    .TICK_DIV(TICK_DIV),
    .SLOTS   (SLOTS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_o    (tick),
    .slot_o    (slot_cur),
    .slot_nxt_o(slot_nxt)
  );

  led_pattern #(
    .SLOTS    (SLOTS),
    .LIT_GRP1 (LIT_GRP1),
    .LIT_GRP2 (LIT_GRP2),
    .LIT_READY(LIT_READY)
  ) u_pattern (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick_i     (tick),
    .slot_nxt_i (slot_nxt),
    .pwr_state_i(pwr_state_i),
    .cfg_done_i (cfg_done_i),
    .led_o      (led_o)
  );

  // R1
  slot0_dark_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (slot_cur == '0 && !$past(tick)) |-> (!led_o || $past(led_o)));

endmodule

// File: tb/led_status_blinker_tb.sv
module led_status_blinker_tb;

  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pwr;
  logic       done;
  logic       led;

  int   checks = 0;
  int   fails  = 0;
  int   bslot  = 0;
  logic exp_led = 1'b0;

  always #2 clk = ~clk;

  led_status_blinker #(
    .TICK_DIV(DIV)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_state_i(pwr),
    .cfg_done_i (done),
    .led_o      (led)
  );

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s slot=%0d actual=%b expected=%b", req, bslot, act, exp);
    end
  endtask

  function automatic logic model(input logic prev, input int s);
    case (pwr)
      2'b00:   model = ~prev;
      2'b01:   model = (s < 5);
      2'b10:   model = (s < 4);
      default: model = done ? 1'b1 : (s < 3);
    endcase
  endfunction

  // One slot: check every cycle, optionally change inputs mid-slot.
  task automatic step_slot(input string req, input bit mid,
                           input logic [1:0] mpwr, input logic mdone);
    for (int i = 0; i < DIV; i++) begin
      chk(led, exp_led, req);
      if (mid && i == DIV / 2) begin
        pwr  = mpwr;
        done = mdone;
      end
      @(negedge clk);
    end
    bslot   = (bslot + 1) % 8;
    exp_led = model(exp_led, bslot);
  endtask

  task automatic run_slots(input int n, input string req);
    for (int k = 0; k < n; k++) step_slot(req, 1'b0, 2'b00, 1'b0);
  endtask

  // R1: reset holds LED off, first slot dark, then align on slot 1
  task automatic test_reset_align();
    bit found = 1'b0;
    rst_n = 1'b0;
    pwr   = 2'b01;
    done  = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(led, 1'b0, "R1 in reset");
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3 * DIV + 8; i++) begin
      @(negedge clk);
      if (led === 1'b1) begin
        found = 1'b1;
        break;
      end
      chk(led, 1'b0, "R1 slot0 dark");
    end
    chk(found, 1'b1, "R1 first boundary seen");
    bslot   = 1;
    exp_led = 1'b1;
  endtask

  task automatic test_grp1();   // R3
    run_slots(16, "R3 group1 5/8");
  endtask

  task automatic test_grp2();   // R4
    pwr = 2'b10;
    run_slots(17, "R4 group2 4/8");
  endtask

  task automatic test_ready();  // R5
    pwr  = 2'b11;
    done = 1'b0;
    run_slots(17, "R5 ready 3/8");
  endtask

  task automatic test_solid();  // R6
    done = 1'b1;
    run_slots(12, "R6 solid on");
  endtask

  task automatic test_idle();   // R7 and R2 period
    pwr  = 2'b00;
    done = 1'b0;
    run_slots(10, "R7 idle toggle R2");
  endtask

  task automatic test_midslot(); // R8
    pwr = 2'b10;
    run_slots(3, "R8 settle");
    step_slot("R8 mid change to solid", 1'b1, 2'b11, 1'b1);
    run_slots(2, "R8 after change");
    step_slot("R8 mid change to group1", 1'b1, 2'b01, 1'b0);
    run_slots(9, "R8 frame continues");
    step_slot("R8 mid change to idle", 1'b1, 2'b00, 1'b0);
    run_slots(3, "R8 idle after change");
  endtask

  task automatic test_reset_again(); // R1 async
    pwr  = 2'b11;
    done = 1'b1;
    run_slots(2, "R1 pre-reset");
    chk(led, 1'b1, "R1 lit before reset");
    rst_n = 1'b0;
    #1;
    chk(led, 1'b0, "R1 async clear");
    @(negedge clk);
    chk(led, 1'b0, "R1 held in reset");
  endtask

  initial begin
    rst_n = 1'b0;
    pwr   = 2'b01;
    done  = 1'b0;
    test_reset_align();
    test_grp1();
    test_grp2();
    test_ready();
    test_solid();
    test_idle();
    test_midslot();
    test_reset_again();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule